// File: doc/BRIEF.md
# PCIe Root Port Power-Up Sequencer

This block brings one PCIe root port out of reset in a fixed, timed order. One start pulse walks it through the whole bring-up. First it holds the link partner in reset. Then it turns on the reference clock. Next it pulses the three core resets: port 1, port 2 and the host bridge. It then holds the link partner in reset once more and releases it. Finally it waits for the partner to settle. A done flag reports the end of that settling time. A stop pulse turns the reference clock off.

Each wait is given in microseconds and scaled by a cycles-per-microsecond parameter. A single down-counter is reloaded at every phase change. Every output is a flop that changes only on the edge where the phase changes. A busy flag is high from the accepted start until done.

Top module: `pcie_pwrup_seq`

## Requirements
- R1: After reset the sequencer is idle. `refclk_en_o`=0, every bit of `perst_n_o`=0, `core_rst_o`=3'b000, `busy_o`=0 and `done_o`=0.
- R2: A start pulse taken while idle or done raises `busy_o` and clears `done_o` on the next edge. It also drives every `perst_n_o` bit low on that edge (e0). `refclk_en_o` rises D_PERST_LO cycles after e0. Here D_x = T_x_US * CYC_PER_US.
- R3: All three core resets change together. `core_rst_o` bit 0 is port 1, bit 1 is port 2 and bit 2 is the host bridge. They are forced to 000 D_PERST_LO+D_REFCLK cycles after e0. They rise to 111 D_RST_PRE cycles later.
- R4: `core_rst_o` stays 111 for exactly D_RST_PULSE cycles, then returns to 000.
- R5: All `perst_n_o` bits rise together. This happens D_RST_POST+D_REL_LOW cycles after the core resets fall.
- R6: `done_o` rises and `busy_o` falls D_SETTLE cycles after `perst_n_o` rises. `busy_o` and `done_o` are never high together.
- R7: A start pulse while `busy_o` is high is ignored. Every later edge of the running sequence keeps its timing.
- R8: A stop pulse clears `refclk_en_o` on the next edge. On that same edge it aborts any running sequence (busy 0, done 0). It leaves `perst_n_o` and `core_rst_o` at their present values, and they stay there.
- R9: A start taken in the done state reruns the full sequence with the same timing. `refclk_en_o` stays high through the rerun.
- R10: When start and stop are high in the same cycle, stop wins and no sequence begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start the bring-up sequence (one-cycle pulse) |
| stop_i | input | 1 | Turn the reference clock off and abort any sequence |
| refclk_en_o | output | 1 | Reference-clock enable; also the clock-on status |
| perst_n_o | output | NUM_PERST | Link-partner resets, active low |
| core_rst_o | output | 3 | Core resets, active high: [0] port 1, [1] port 2, [2] host bridge |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Partner released and settled |

## Verification
The bench drives a start pulse so that the design samples it on edge e0. It then samples once per cycle at the falling edge; sample c sees the state after edge e0+c-1. Each output that follows a phase change comes straight from a flop loaded on that edge. So the refclk rise is due at sample D_PERST_LO+1, the core-reset rise at D_PERST_LO+D_REFCLK+D_RST_PRE+1, and each later event one phase duration after the previous one. The bench computes these indices from the same microsecond values and compares the first sample at which each output changes.

A stop, a start in the done state, or a combined start and stop each takes effect at the very next sample. The bench checks those one sample after the pulse, and checks again a few samples later to confirm the state holds. Ignored start pulses are swept over every cycle of the sequence, and stop pulses over every phase.

// File: rtl/pcie_pwrup_pkg.sv
package pcie_pwrup_pkg;

  localparam int unsigned NUM_CORE_RST = 3;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_PERST_LO,
    PH_REFCLK,
    PH_RST_PRE,
    PH_RST_PULSE,
    PH_RST_POST,
    PH_REL_LOW,
    PH_SETTLE,
    PH_DONE
  } phase_e;

  function automatic logic is_timed(phase_e p);
    return (p != PH_IDLE) && (p != PH_DONE);
  endfunction

endpackage

// File: rtl/pcie_pwrup_timer.sv
module pcie_pwrup_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/pcie_pwrup_ctrl.sv
module pcie_pwrup_ctrl
  import pcie_pwrup_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned D_PERST_LO  = 1,
  parameter int unsigned D_REFCLK    = 1,
  parameter int unsigned D_RST_PRE   = 1,
  parameter int unsigned D_RST_PULSE = 1,
  parameter int unsigned D_RST_POST  = 1,
  parameter int unsigned D_REL_LOW   = 1,
  parameter int unsigned D_SETTLE    = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             expired_i,
  output phase_e           state_q_o,
  output phase_e           state_d_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o
);

  phase_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (stop_i) begin
      state_d = PH_IDLE;
    end else begin
      unique case (state_q)
        PH_IDLE, PH_DONE: if (start_i) state_d = PH_PERST_LO;
        PH_PERST_LO:      if (expired_i) state_d = PH_REFCLK;
        PH_REFCLK:        if (expired_i) state_d = PH_RST_PRE;
        PH_RST_PRE:       if (expired_i) state_d = PH_RST_PULSE;
        PH_RST_PULSE:     if (expired_i) state_d = PH_RST_POST;
        PH_RST_POST:      if (expired_i) state_d = PH_REL_LOW;
        PH_REL_LOW:       if (expired_i) state_d = PH_SETTLE;
        PH_SETTLE:        if (expired_i) state_d = PH_DONE;
        default:          state_d = PH_IDLE;
      endcase
    end
  end

  // Counter is loaded with duration-1 on phase entry: the phase lasts D cycles.
  always_comb begin
    load_val_o = '0;
    unique case (state_d)
      PH_PERST_LO:  load_val_o = CNT_W'(D_PERST_LO - 1);
      PH_REFCLK:    load_val_o = CNT_W'(D_REFCLK - 1);
      PH_RST_PRE:   load_val_o = CNT_W'(D_RST_PRE - 1);
      PH_RST_PULSE: load_val_o = CNT_W'(D_RST_PULSE - 1);
      PH_RST_POST:  load_val_o = CNT_W'(D_RST_POST - 1);
      PH_REL_LOW:   load_val_o = CNT_W'(D_REL_LOW - 1);
      PH_SETTLE:    load_val_o = CNT_W'(D_SETTLE - 1);
      default:      load_val_o = '0;
    endcase
  end

  assign load_o = (state_d != state_q) && is_timed(state_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PH_IDLE;
    else         state_q <= state_d;
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;

endmodule

// File: rtl/pcie_pwrup_outreg.sv
module pcie_pwrup_outreg
  import pcie_pwrup_pkg::*;
#(
  parameter int unsigned NUM_PERST = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    stop_i,
  input  phase_e                  state_q_i,
  input  phase_e                  state_d_i,
  output logic                    refclk_en_o,
  output logic [NUM_PERST-1:0]    perst_n_o,
  output logic [NUM_CORE_RST-1:0] core_rst_o,
  output logic                    busy_o,
  output logic                    done_o
);

  logic enter;
  assign enter = (state_d_i != state_q_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  refclk_en_o <= 1'b0;
    else if (stop_i)                              refclk_en_o <= 1'b0;
    else if (enter && state_d_i == PH_REFCLK)     refclk_en_o <= 1'b1;
  end

  for (genvar i = 0; i < NUM_PERST; i++) begin : g_perst
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        perst_n_o[i] <= 1'b0;
      end else if (enter && !stop_i) begin
        if (state_d_i == PH_PERST_LO || state_d_i == PH_REL_LOW) perst_n_o[i] <= 1'b0;
        else if (state_d_i == PH_SETTLE)                         perst_n_o[i] <= 1'b1;
      end
    end
  end

  for (genvar j = 0; j < NUM_CORE_RST; j++) begin : g_core
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        core_rst_o[j] <= 1'b0;
      end else if (enter && !stop_i) begin
        if (state_d_i == PH_RST_PULSE)                             core_rst_o[j] <= 1'b1;
        else if (state_d_i == PH_RST_PRE || state_d_i == PH_RST_POST) core_rst_o[j] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      busy_o <= is_timed(state_d_i);
      done_o <= (state_d_i == PH_DONE);
    end
  end

endmodule

// File: rtl/pcie_pwrup_seq.sv
module pcie_pwrup_seq
  import pcie_pwrup_pkg::*;
#(
  parameter int unsigned NUM_PERST      = 2,
  parameter int unsigned CYC_PER_US     = 200,
  parameter int unsigned T_PERST_LO_US  = 1000,
  parameter int unsigned T_REFCLK_US    = 1000,
  parameter int unsigned T_RST_PRE_US   = 1000,
  parameter int unsigned T_RST_PULSE_US = 100000,
  parameter int unsigned T_RST_POST_US  = 5000,
  parameter int unsigned T_REL_LOW_US   = 1000,
  parameter int unsigned T_SETTLE_US    = 250000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 stop_i,
  output logic                 refclk_en_o,
  output logic [NUM_PERST-1:0] perst_n_o,
  output logic [2:0]           core_rst_o,
  output logic                 busy_o,
  output logic                 done_o
);

  localparam int unsigned D_PERST_LO  = T_PERST_LO_US  * CYC_PER_US;
  localparam int unsigned D_REFCLK    = T_REFCLK_US    * CYC_PER_US;
  localparam int unsigned D_RST_PRE   = T_RST_PRE_US   * CYC_PER_US;
  localparam int unsigned D_RST_PULSE = T_RST_PULSE_US * CYC_PER_US;
  localparam int unsigned D_RST_POST  = T_RST_POST_US  * CYC_PER_US;
  localparam int unsigned D_REL_LOW   = T_REL_LOW_US   * CYC_PER_US;
  localparam int unsigned D_SETTLE    = T_SETTLE_US    * CYC_PER_US;
  localparam int unsigned D_MAX_A = (D_PERST_LO > D_REFCLK) ? D_PERST_LO : D_REFCLK;
  localparam int unsigned D_MAX_B = (D_RST_PRE > D_RST_PULSE) ? D_RST_PRE : D_RST_PULSE;
  localparam int unsigned D_MAX_C = (D_RST_POST > D_REL_LOW) ? D_RST_POST : D_REL_LOW;
  localparam int unsigned D_MAX_D = (D_MAX_A > D_MAX_B) ? D_MAX_A : D_MAX_B;
  localparam int unsigned D_MAX_E = (D_MAX_C > D_SETTLE) ? D_MAX_C : D_SETTLE;
  localparam int unsigned D_MAX   = (D_MAX_D > D_MAX_E) ? D_MAX_D : D_MAX_E;
  localparam int unsigned CNT_W   = (D_MAX > 1) ? $clog2(D_MAX) : 1;

  phase_e           state_q, state_d;
  logic             load, expired;
  logic [CNT_W-1:0] load_val;

  pcie_pwrup_ctrl #(
    .CNT_W       (CNT_W),
    .D_PERST_LO  (D_PERST_LO),
    .D_REFCLK    (D_REFCLK),
    .D_RST_PRE   (D_RST_PRE),
    .D_RST_PULSE (D_RST_PULSE),
    .D_RST_POST  (D_RST_POST),
    .D_REL_LOW   (D_REL_LOW),
    .D_SETTLE    (D_SETTLE)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .expired_i  (expired),
    .state_q_o  (state_q),
    .state_d_o  (state_d),
    .load_o     (load),
    .load_val_o (load_val)
  );

  pcie_pwrup_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .expired_o  (expired)
  );

  pcie_pwrup_outreg #(.NUM_PERST(NUM_PERST)) u_outreg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stop_i      (stop_i),
    .state_q_i   (state_q),
    .state_d_i   (state_d),
    .refclk_en_o (refclk_en_o),
    .perst_n_o   (perst_n_o),
    .core_rst_o  (core_rst_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

endmodule

// File: rtl/pcie_pwrup_seq_chk.sv
module pcie_pwrup_seq_chk #(
  parameter int unsigned NUM_PERST = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic                 stop_i,
  input logic                 refclk_en_o,
  input logic [NUM_PERST-1:0] perst_n_o,
  input logic [2:0]           core_rst_o,
  input logic                 busy_o,
  input logic                 done_o
);

  p_start_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !stop_i && !busy_o |=> busy_o && !done_o && (perst_n_o == '0));

  p_core_rst_group_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_rst_o == 3'b000) || (core_rst_o == 3'b111));

  p_pulse_under_refclk_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_rst_o[0]) |-> refclk_en_o && busy_o);

  p_perst_group_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perst_n_o == '0) || (perst_n_o == '1));

  p_busy_done_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  p_done_after_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));

  p_busy_runs_on_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !stop_i |=> busy_o || done_o);

  p_refclk_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !refclk_en_o && !busy_o && !done_o);

  p_stop_holds_resets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> $stable(perst_n_o) && $stable(core_rst_o));

endmodule

bind pcie_pwrup_seq pcie_pwrup_seq_chk #(.NUM_PERST(NUM_PERST)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .refclk_en_o (refclk_en_o),
  .perst_n_o   (perst_n_o),
  .core_rst_o  (core_rst_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/pcie_pwrup_seq_bench.sv
`timescale 1ns/1ps
module pcie_pwrup_seq_bench;

  localparam int NP = 2;
  localparam int C  = 2;
  localparam int N1 = 2 * C;
  localparam int N2 = 3 * C;
  localparam int N3 = 1 * C;
  localparam int N4 = 4 * C;
  localparam int N5 = 2 * C;
  localparam int N6 = 3 * C;
  localparam int N7 = 5 * C;
  localparam int E_REF = N1 + 1;
  localparam int E_RA  = N1 + N2 + N3 + 1;
  localparam int E_RD  = E_RA + N4;
  localparam int E_PR  = E_RD + N5 + N6;
  localparam int E_DN  = E_PR + N7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic stop = 1'b0;
  logic refclk_en, busy, done;
  logic [NP-1:0] perst_n;
  logic [2:0] core_rst;
  int n_cmp = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  pcie_pwrup_seq #(
    .NUM_PERST(NP), .CYC_PER_US(C),
    .T_PERST_LO_US(2), .T_REFCLK_US(3), .T_RST_PRE_US(1), .T_RST_PULSE_US(4),
    .T_RST_POST_US(2), .T_REL_LOW_US(3), .T_SETTLE_US(5)
  ) u_pcie_pwrup_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .refclk_en_o(refclk_en), .perst_n_o(perst_n), .core_rst_o(core_rst),
    .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_stop();
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    @(negedge clk);
  endtask

  // Start at sample 0; sample c sees the state after edge e0+c-1.
  task automatic run_seq(input int ign, input bit fresh);
    int t_ref = -1, t_ra = -1, t_rd = -1, t_pr = -1, t_dn = -1, t_bz = -1;
    start = 1'b1;
    for (int c = 1; c <= E_DN + 2; c++) begin
      @(negedge clk);
      start = (c == ign);
      if (c == 1) begin
        chk("R2 busy on start", busy, 1);
        chk("R2 perst low on start", int'(perst_n), 0);
        chk("R9 done cleared on start", done, 0);
      end
      if (t_ref < 0 && refclk_en) t_ref = c;
      if (t_ra < 0 && core_rst == 3'b111) t_ra = c;
      if (t_ra >= 0 && t_rd < 0 && core_rst == 3'b000) t_rd = c;
      if (c > 1 && t_pr < 0 && perst_n == '1) t_pr = c;
      if (t_dn < 0 && done) t_dn = c;
      if (t_bz < 0 && !busy) t_bz = c;
    end
    start = 1'b0;
    chk(fresh ? "R2 refclk rise" : "R9 refclk held", t_ref, fresh ? E_REF : 1);
    chk(ign > 0 ? "R7 core rst rise" : "R3 core rst rise", t_ra, E_RA);
    chk("R4 core rst width", t_rd - t_ra, N4);
    chk(ign > 0 ? "R7 perst release" : "R5 perst release", t_pr, E_PR);
    chk("R6 done rise", t_dn, E_DN);
    chk("R6 busy fall", t_bz, E_DN);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    logic [NP-1:0] cap_p;
    logic [2:0] cap_r;
    repeat (3) @(negedge clk);
    chk("R1 refclk", refclk_en, 0);
    chk("R1 perst", int'(perst_n), 0);
    chk("R1 core rst", int'(core_rst), 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Full run, then start pulses swept across every busy cycle (R7).
    run_seq(0, 1'b1);
    run_seq(0, 1'b0);  // R9 restart from done
    for (int ign = 1; ign < E_DN; ign++) begin
      pulse_stop();
      run_seq(ign, 1'b1);
    end

    // Stop swept across every phase (R8).
    for (int p = 1; p < E_DN; p++) begin
      pulse_stop();
      start = 1'b1;
      for (int c = 1; c <= p; c++) begin
        @(negedge clk);
        start = 1'b0;
      end
      cap_p = perst_n;
      cap_r = core_rst;
      stop = 1'b1;
      @(negedge clk);
      stop = 1'b0;
      chk("R8 refclk off", refclk_en, 0);
      chk("R8 perst held", int'(perst_n), int'(cap_p));
      chk("R8 core rst held", int'(core_rst), int'(cap_r));
      chk("R8 busy cleared", busy, 0);
      repeat (4) @(negedge clk);
      chk("R8 aborted stays", int'({busy, done, refclk_en}), 0);
      chk("R8 core rst still held", int'(core_rst), int'(cap_r));
    end

    // Stop inside the pulse leaves core resets high; pre-phase clears them (R3).
    pulse_stop();
    start = 1'b1;
    for (int c = 1; c <= E_RA; c++) begin
      @(negedge clk);
      start = 1'b0;
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R8 pulse held after stop", int'(core_rst), 7);
    start = 1'b1;
    for (int c = 1; c <= N1 + N2 + 1; c++) begin
      @(negedge clk);
      start = 1'b0;
      if (c == N1 + N2) chk("R3 leftover held before pre", int'(core_rst), 7);
      if (c == N1 + N2 + 1) chk("R3 pre phase clears", int'(core_rst), 0);
    end
    repeat (E_DN) @(negedge clk);
    chk("R6 done after rerun", done, 1);

    // Start and stop together: stop wins (R10).
    cap_p = perst_n;
    start = 1'b1;
    stop = 1'b1;
    @(negedge clk);
    start = 1'b0;
    stop = 1'b0;
    chk("R10 no busy", busy, 0);
    chk("R10 refclk off", refclk_en, 0);
    chk("R10 perst held", int'(perst_n), int'(cap_p));
    repeat (N1 + 2) @(negedge clk);
    chk("R10 still idle", int'({busy, done, refclk_en}), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

endmodule